// File: doc/BRIEF.md
# Shadowed Display Configuration Register Bank

This block holds the configuration registers of a display controller in several copies, split into independent groups: one general group (display mode and other controller-wide settings), a parameterized number of window groups and one cursor group. The host bus writes only the assembly copy. A state-control register commits groups in two steps. An update request copies assembly into an armed copy. An activate request then moves the values into the active copy, which drives the display pipeline.

The general group has two copies, and its activate request copies assembly straight into active. Window and cursor groups have three copies. Their activate request copies the armed copy, so later assembly writes cannot reach the screen by accident. An activate takes effect on the same clock edge as the write when the active display-mode field is zero (the controller is stopped). Otherwise it stays pending until the next frame-boundary strobe. A state-access register selects whether bus reads return the assembly copy or the active copy. This lets software confirm that a commit has landed, or that the controller has gone idle.

Top module: `shreg_bank`

## Requirements
- R1: After reset, all assembly, armed and active copies, all pending requests and the read-select bit are zero. The controller is therefore stopped and `ctl_idle` is 1.
- R2: A bus write at a group register address changes only that register's assembly copy. While the read-select bit is 0, a read at that address returns the assembly value. Addresses: general register 0x02, window w register r at 0x10 + w*S + r (S is REGS rounded up to a power of two), cursor register r at 0x30 + r.
- R3: Address 0x01 holds the read-select bit in bit 0. Value 1 makes group-register reads return the active copy. Value 0 returns the assembly copy.
- R4: The state-control register at 0x00 places the general activate bit at bit 0, window w at bit 1+w, and the cursor at bit 7. Each group's update bit sits 8 positions above its activate bit. A read of 0x00 returns the pending activate bits in [7:0]. Any mix of groups may be set in one write.
- R5: An update bit copies a window or cursor group's assembly values into its armed copy on the write edge. It does not change the active copy.
- R6: When the active display-mode field (general register bits [1:0]) is zero, an activate request moves the values into the active copy on the write edge itself, and leaves nothing pending.
- R7: When the mode field is non-zero, an activate request stays pending and readable until the next clock edge with `frame_tick` high. On that edge the transfer happens and the pending bit clears.
- R8: For window and cursor groups, activate copies the armed copy, not assembly values written after the last update. If update and activate arrive in the same write, the newly armed value is used.
- R9: For the general group, activate copies the assembly copy directly into active, with no update step.
- R10: A group with no activate request keeps its active values across frame strobes, even when other groups commit.
- R11: `ctl_idle` is 1 exactly when the active mode field is zero. Writing mode zero and committing the general group while running stops the controller at the next frame strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| frame_tick | input | 1 | One-cycle frame-boundary strobe |
| act_general | output | DW | Active copy of the general register |
| act_win | output | NWIN*REGS*DW | Active copies of all window registers |
| act_cursor | output | REGS*DW | Active copies of the cursor registers |
| ctl_idle | output | 1 | Active mode field is zero |

## Verification
The assertions inside each group watch, on every cycle, the rules that govern pending requests and the active copy. A request made while stopped must complete on the same edge. A request made while running must wait with the active values held. A pending bit must clear at a frame strobe. A group without a request must keep its active values. An update must capture the assembly values into the armed copy. Other properties depend on what was written earlier, so only the bench's sequences can show them. These are the address map and bit layout of the control register, the read-back selection, armed versus newer assembly values, independence between groups, and the stop handshake through the general group.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  localparam int CTRL_ADDR   = 'h00;
  localparam int ACCESS_ADDR = 'h01;
  localparam int GEN_ADDR    = 'h02;
  localparam int WIN_BASE    = 'h10;
  localparam int CUR_BASE    = 'h30;
  localparam int CUR_SLOT    = 6;   // cursor occupies window slot 6
  localparam int UPD_SHIFT   = 8;   // update bit offset above activate bit
  localparam int MODE_W      = 2;   // display-mode field width in general reg

  // Activate-bit position of group g: 0 general, 1..nwin windows, last cursor
  function automatic int grp_bit(input int g, input int nwin);
    if (g == 0)
      return 0;
    else if (g <= nwin)
      return g;
    else
      return 1 + CUR_SLOT;
  endfunction

endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
  import shreg_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NWIN   = 3,
  parameter int REGS   = 2,
  parameter int RIDX_W = 1,
  parameter int NGRP   = NWIN + 2
) (
  input  logic [AW-1:0]     addr,
  output logic              hit_ctrl,
  output logic              hit_access,
  output logic [NGRP-1:0]   grp_hit,
  output logic [RIDX_W-1:0] reg_idx
);

  localparam int STRIDE = 1 << RIDX_W;
  localparam logic [AW-1:0] CB = AW'(CUR_BASE);

  logic idx_ok;

  assign reg_idx    = addr[RIDX_W-1:0];
  assign idx_ok     = (int'(reg_idx) < REGS);
  assign hit_ctrl   = (addr == AW'(CTRL_ADDR));
  assign hit_access = (addr == AW'(ACCESS_ADDR));
  assign grp_hit[0] = (addr == AW'(GEN_ADDR));

  for (genvar w = 0; w < NWIN; w++) begin : g_win_dec
    localparam logic [AW-1:0] WB = AW'(WIN_BASE + w * STRIDE);
    assign grp_hit[1+w] = (addr[AW-1:RIDX_W] == WB[AW-1:RIDX_W]) && idx_ok;
  end

  assign grp_hit[NGRP-1] = (addr[AW-1:RIDX_W] == CB[AW-1:RIDX_W]) && idx_ok;

endmodule

// File: rtl/shreg_group.sv
module shreg_group #(
  parameter int DW     = 32,
  parameter int NREG   = 2,
  parameter int IW     = 1,
  parameter bit TRIPLE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     upd_req,
  input  logic                     act_req,
  input  logic                     stop_mode,
  input  logic                     frame_tick,
  output logic                     pending,
  output logic [NREG-1:0][DW-1:0]  asm_o,
  output logic [NREG-1:0][DW-1:0]  act_o
);

  logic [NREG-1:0][DW-1:0] asm_q, asm_d;
  logic [NREG-1:0][DW-1:0] act_q, act_d;
  logic [NREG-1:0][DW-1:0] src;
  logic                    pend_q, pend_d;
  logic                    req_eff, fire;

  // assembly copy
  always_comb begin
    asm_d = asm_q;
    for (int r = 0; r < NREG; r++)
      if (wr_en && (wr_idx == IW'(r)))
        asm_d[r] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     asm_q <= '0;
    else if (wr_en) asm_q <= asm_d;
  end

  // armed copy (triple-buffered variant only)
  if (TRIPLE) begin : g_armed
    logic [NREG-1:0][DW-1:0] arm_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_q <= '0;
      else if (upd_req) arm_q <= asm_q;
    end

    assign src = upd_req ? asm_q : arm_q;

    AST_ARM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |=> (arm_q == $past(asm_q))); // R5
  end else begin : g_direct
    assign src = asm_q;
  end

  // pending request and active transfer
  always_comb begin
    req_eff = pend_q | act_req;
    fire    = req_eff & (stop_mode | frame_tick);
    pend_d  = req_eff & ~fire;
    act_d   = fire ? src : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (fire) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
  assign asm_o   = asm_q;
  assign act_o   = act_q;

  AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && stop_mode) |=> !pend_q); // R6

  AST_RUN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && !stop_mode && !frame_tick) |=> (pend_q && $stable(act_q))); // R7

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && frame_tick) |=> !pend_q); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !act_req) |=> $stable(act_q)); // R10

endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
  import shreg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int NWIN = 3,
  parameter int REGS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_we,
  input  logic [AW-1:0]                      bus_addr,
  input  logic [DW-1:0]                      bus_wdata,
  output logic [DW-1:0]                      bus_rdata,
  input  logic                               frame_tick,
  output logic [DW-1:0]                      act_general,
  output logic [NWIN-1:0][REGS-1:0][DW-1:0]  act_win,
  output logic [REGS-1:0][DW-1:0]            act_cursor,
  output logic                               ctl_idle
);

  localparam int NGRP   = NWIN + 2;
  localparam int RIDX_W = (REGS > 1) ? $clog2(REGS) : 1;
  localparam int CUR_G  = NGRP - 1;

  logic                              hit_ctrl, hit_access;
  logic [NGRP-1:0]                   grp_hit;
  logic [RIDX_W-1:0]                 reg_idx;
  logic                              ctrl_wr;
  logic [NGRP-1:0]                   upd_vec, act_vec, pend_vec;
  logic [7:0]                        pend8;
  logic                              sel_q, sel_d;
  logic                              stop_mode;
  logic [0:0][DW-1:0]                gen_asm, gen_act;
  logic [NWIN-1:0][REGS-1:0][DW-1:0] win_asm, win_act;
  logic [REGS-1:0][DW-1:0]           cur_asm, cur_act;

  shreg_decode #(
    .AW(AW), .NWIN(NWIN), .REGS(REGS), .RIDX_W(RIDX_W), .NGRP(NGRP)
  ) u_dec (
    .addr       (bus_addr),
    .hit_ctrl   (hit_ctrl),
    .hit_access (hit_access),
    .grp_hit    (grp_hit),
    .reg_idx    (reg_idx)
  );

  assign ctrl_wr = bus_we & hit_ctrl;

  for (genvar g = 0; g < NGRP; g++) begin : g_req
    localparam int AB = grp_bit(g, NWIN);
    assign act_vec[g] = ctrl_wr & bus_wdata[AB];
    assign upd_vec[g] = ctrl_wr & bus_wdata[AB + UPD_SHIFT];
  end

  always_comb begin
    pend8 = '0;
    for (int g = 0; g < NGRP; g++)
      pend8[grp_bit(g, NWIN)] = pend_vec[g];
  end

  // read-select register
  always_comb begin
    sel_d = sel_q;
    if (bus_we && hit_access) sel_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign stop_mode = (gen_act[0][MODE_W-1:0] == '0);

  shreg_group #(.DW(DW), .NREG(1), .IW(1), .TRIPLE(1'b0)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_we & grp_hit[0]),
    .wr_idx     (1'b0),
    .wr_data    (bus_wdata),
    .upd_req    (upd_vec[0]),
    .act_req    (act_vec[0]),
    .stop_mode  (stop_mode),
    .frame_tick (frame_tick),
    .pending    (pend_vec[0]),
    .asm_o      (gen_asm),
    .act_o      (gen_act)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    shreg_group #(.DW(DW), .NREG(REGS), .IW(RIDX_W), .TRIPLE(1'b1)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_we & grp_hit[1+w]),
      .wr_idx     (reg_idx),
      .wr_data    (bus_wdata),
      .upd_req    (upd_vec[1+w]),
      .act_req    (act_vec[1+w]),
      .stop_mode  (stop_mode),
      .frame_tick (frame_tick),
      .pending    (pend_vec[1+w]),
      .asm_o      (win_asm[w]),
      .act_o      (win_act[w])
    );
  end

  shreg_group #(.DW(DW), .NREG(REGS), .IW(RIDX_W), .TRIPLE(1'b1)) u_cur (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_we & grp_hit[CUR_G]),
    .wr_idx     (reg_idx),
    .wr_data    (bus_wdata),
    .upd_req    (upd_vec[CUR_G]),
    .act_req    (act_vec[CUR_G]),
    .stop_mode  (stop_mode),
    .frame_tick (frame_tick),
    .pending    (pend_vec[CUR_G]),
    .asm_o      (cur_asm),
    .act_o      (cur_act)
  );

  // read-back mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)
      bus_rdata[7:0] = pend8;
    else if (hit_access)
      bus_rdata[0] = sel_q;
    else if (grp_hit[0])
      bus_rdata = sel_q ? gen_act[0] : gen_asm[0];
    else if (grp_hit[CUR_G])
      bus_rdata = sel_q ? cur_act[reg_idx] : cur_asm[reg_idx];
    else
      for (int w = 0; w < NWIN; w++)
        if (grp_hit[1+w])
          bus_rdata = sel_q ? win_act[w][reg_idx] : win_asm[w][reg_idx];
  end

  assign act_general = gen_act[0];
  assign act_win     = win_act;
  assign act_cursor  = cur_act;
  assign ctl_idle    = stop_mode;

  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_idle && !act_vec[0]) |=> ctl_idle); // R11

endmodule

// File: tb/shreg_bank_tb.sv
module shreg_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, AW = 8, NWIN = 3, REGS = 2;

  logic                               clk = 1'b0;
  logic                               rst_n;
  logic                               bus_we;
  logic [AW-1:0]                      bus_addr;
  logic [DW-1:0]                      bus_wdata;
  logic [DW-1:0]                      bus_rdata;
  logic                               frame_tick;
  logic [DW-1:0]                      act_general;
  logic [NWIN-1:0][REGS-1:0][DW-1:0]  act_win;
  logic [REGS-1:0][DW-1:0]            act_cursor;
  logic                               ctl_idle;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shreg_bank #(.DW(DW), .AW(AW), .NWIN(NWIN), .REGS(REGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
    .act_general(act_general), .act_win(act_win), .act_cursor(act_cursor),
    .ctl_idle(ctl_idle)
  );

  // op: 0 write, 1 read-check, 2 frame strobe, 3 idle-check
  localparam int NV = 52;
  localparam logic [45:0] VEC [NV] = '{
    {2'd1, 8'h00, 32'h0000_0000, 4'd1},   // R1 nothing pending
    {2'd0, 8'h10, 32'hAAAA_0001, 4'd2},   // R2
    {2'd1, 8'h10, 32'hAAAA_0001, 4'd2},   // R2 assembly readback
    {2'd0, 8'h01, 32'h0000_0001, 4'd3},   // R3 select active
    {2'd1, 8'h10, 32'h0000_0000, 4'd3},   // R3 active untouched
    {2'd0, 8'h00, 32'h0000_0200, 4'd5},   // R5 update win0
    {2'd1, 8'h10, 32'h0000_0000, 4'd5},   // R5 active unchanged
    {2'd0, 8'h00, 32'h0000_0002, 4'd6},   // R6 activate while stopped
    {2'd1, 8'h10, 32'hAAAA_0001, 4'd6},   // R6 immediate
    {2'd1, 8'h00, 32'h0000_0000, 4'd6},   // R6 nothing pending
    {2'd0, 8'h02, 32'h0000_0005, 4'd9},   // R9 mode=1
    {2'd1, 8'h02, 32'h0000_0000, 4'd9},   // R9 not yet active
    {2'd3, 8'h00, 32'h0000_0001, 4'd11},  // R11 still idle
    {2'd0, 8'h00, 32'h0000_0001, 4'd9},   // R9 general activate
    {2'd1, 8'h02, 32'h0000_0005, 4'd9},   // R9 direct copy
    {2'd3, 8'h00, 32'h0000_0000, 4'd11},  // R11 running
    {2'd0, 8'h11, 32'h0000_BEEF, 4'd7},   // R7
    {2'd0, 8'h00, 32'h0000_0202, 4'd7},   // R7 update+activate while running
    {2'd1, 8'h00, 32'h0000_0002, 4'd7},   // R7 pending visible
    {2'd1, 8'h11, 32'h0000_0000, 4'd7},   // R7 waits
    {2'd2, 8'h00, 32'h0000_0000, 4'd7},   // frame
    {2'd1, 8'h11, 32'h0000_BEEF, 4'd7},   // R7 landed
    {2'd1, 8'h00, 32'h0000_0000, 4'd7},   // R7 pending cleared
    {2'd0, 8'h10, 32'h0000_1111, 4'd8},   // R8
    {2'd0, 8'h00, 32'h0000_0200, 4'd8},   // R8 arm 1111
    {2'd0, 8'h10, 32'h0000_2222, 4'd8},   // R8 newer assembly
    {2'd0, 8'h00, 32'h0000_0002, 4'd8},   // R8 activate
    {2'd2, 8'h00, 32'h0000_0000, 4'd8},
    {2'd1, 8'h10, 32'h0000_1111, 4'd8},   // R8 armed value wins
    {2'd0, 8'h30, 32'h0000_C0C0, 4'd4},   // R4 cursor
    {2'd0, 8'h12, 32'h0000_5151, 4'd4},   // R4 window 1
    {2'd0, 8'h00, 32'h0000_8400, 4'd4},   // R4 update cursor(15)+win1(10)
    {2'd0, 8'h00, 32'h0000_0080, 4'd4},   // R4 activate cursor only
    {2'd1, 8'h00, 32'h0000_0080, 4'd4},   // R4 bit7 pending
    {2'd2, 8'h00, 32'h0000_0000, 4'd4},
    {2'd1, 8'h30, 32'h0000_C0C0, 4'd4},   // R4 cursor landed
    {2'd1, 8'h12, 32'h0000_0000, 4'd10},  // R10 win1 not requested
    {2'd0, 8'h00, 32'h0000_0004, 4'd4},   // R4 activate win1
    {2'd2, 8'h00, 32'h0000_0000, 4'd4},
    {2'd1, 8'h12, 32'h0000_5151, 4'd4},   // R4 win1 landed
    {2'd2, 8'h00, 32'h0000_0000, 4'd10},
    {2'd1, 8'h10, 32'h0000_1111, 4'd10},  // R10 held over frame
    {2'd0, 8'h01, 32'h0000_0000, 4'd3},   // R3 back to assembly
    {2'd1, 8'h10, 32'h0000_2222, 4'd2},   // R2 assembly view
    {2'd0, 8'h01, 32'h0000_0001, 4'd3},
    {2'd0, 8'h02, 32'h0000_0004, 4'd11},  // R11 mode=0
    {2'd0, 8'h00, 32'h0000_0001, 4'd11},  // R11 general commit
    {2'd1, 8'h02, 32'h0000_0005, 4'd11},  // R11 still running
    {2'd2, 8'h00, 32'h0000_0000, 4'd11},
    {2'd3, 8'h00, 32'h0000_0001, 4'd11},  // R11 stopped
    {2'd0, 8'h11, 32'h0000_7777, 4'd6},   // R6
    {2'd0, 8'h00, 32'h0000_0202, 4'd6}    // R6 immediate again
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string req, input logic [DW-1:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; frame_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state at ports
    check("R1", {31'd0, ctl_idle}, 32'd1);
    check("R1", act_general, 32'd0);
    bus_read(8'h10, "R1", 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]    op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         rq;
      op = VEC[i][45:44]; a = VEC[i][43:36]; d = VEC[i][35:4];
      rq = $sformatf("R%0d", VEC[i][3:0]);
      case (op)
        2'd0: bus_write(a, d);
        2'd1: bus_read(a, rq, d);
        2'd2: frame_pulse();
        default: begin
          @(negedge clk);
          check(rq, {31'd0, ctl_idle}, d);
        end
      endcase
    end

    // R6 immediate transfer visible on the active output port
    @(negedge clk);
    check("R6", act_win[0][1], 32'h0000_7777);
    bus_read(8'h00, "R6", 32'd0);
    // R9 active general reg on port
    check("R9", act_general, 32'h0000_0004);
    check("R4", act_cursor[0], 32'h0000_C0C0);

    // R1 reset in the middle of activity clears everything
    bus_write(8'h02, 32'h1);
    bus_write(8'h00, 32'h1);
    bus_write(8'h00, 32'h0002);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", {31'd0, ctl_idle}, 32'd1);
    check("R1", act_win[0][1], 32'd0);
    bus_read(8'h00, "R1", 32'd0);
    bus_read(8'h01, "R1", 32'd0);
    bus_read(8'h11, "R1", 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule